// File: doc/BRIEF.md
# Multi-Channel DMA Control and Interrupt Register File

This block is the software-visible control plane of a multi-channel DMA engine. It serves up to eight channels, and each channel has two directions: write and read. Each direction has its own register window. The window holds an enable, a doorbell, a list pointer, the transfer size, the source and destination addresses, a mode control, a status code, interrupt flags and their setup, and the addresses and data for message-signalled interrupts. Software reaches the windows over a simple 32-bit register bus. The block decodes channel and direction from the address: channel `c` and direction `d` (0 = write, 1 = read) sit at byte base `c*0x200 + d*0x100`.

The transfer engine lies outside the block. For every channel direction, the engine reports three things: that it is running, that it completed, and that it aborted. The block turns these reports into a 2-bit status code and into sticky done and abort flags. From the flags and the interrupt setup it forms a local interrupt level. For events whose remote enable is set, it issues one message write request that carries the stored address and data. In return, the block drives the engine with enable levels, list-mode levels and one-cycle start pulses.

Channel directions are numbered `u = 2*c + d` on all per-unit vector ports.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero, and `chan_en`, `list_mode`, `start_pulse`, `irq_local` and `msg_valid` are all low.
- R2: Each unit's window stores full 32-bit values at offsets 0x10/0x14 (list pointer low/high), 0x1C (size), 0x20/0x24 (source), 0x28/0x2C (destination), 0x90/0x94 (stop message address), 0xA0/0xA4 (abort message address) and 0xA8 (message data). Offset 0x00 bit0 (enable), offset 0x34 bit0 (list mode) and offset 0x88 (interrupt setup, bits 0 and 2 to 6 only, read back masked with 0x7D) are also stored. Every window is independent of all the others.
- R3: Reads of any other offset return zero, and writes to such offsets change nothing. The doorbell (0x04) and interrupt clear (0x8C) read zero. Status (0x80) and interrupt status (0x84) are read-only.
- R4: A write with bit0 set to offset 0x04 of an enabled unit raises `start_pulse[u]` for exactly the one cycle after the write. A disabled unit produces no pulse.
- R5: Status (0x80, bits 1:0) reads 0 while the unit is disabled, and engine inputs do not change it then. While the unit is enabled, an abort sets 2, else a done sets 3, else running sets 1; otherwise the value holds.
- R6: Interrupt status (0x84) holds the stop flag in bit0 and the abort flag in bit2. `eng_done[u]` sets the stop flag and `eng_abort[u]` sets the abort flag. A flag stays set until cleared, including across a clear of the enable.
- R7: Writing 1 to bit0 or bit2 of 0x8C clears the stop or abort flag respectively; zero bits have no effect. A set event in the same cycle as a clear wins.
- R8: `irq_local[u]` is high while (stop flag AND setup bit4) OR (abort flag AND setup bit6).
- R9: When a flag goes from 0 to 1 with its remote enable set (setup bit3 for stop, bit5 for abort), exactly one message request is queued. The request carries {0x94,0x90} or {0xA4,0xA0} as the 64-bit address and 0xA8 as the data. A request appears on `msg_valid` no earlier than the second clock edge after the event. Requests leave one per cycle: the lowest `u` goes first, and within a unit stop goes before abort. An event whose flag is already set queues nothing.
- R10: `chan_en[u]` and `list_mode[u]` follow bit0 of the unit's enable and list-mode registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (12) | Byte address: channel, direction, offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_run | input | 2*NCH | Engine running, per unit |
| eng_done | input | 2*NCH | Engine completion event, per unit |
| eng_abort | input | 2*NCH | Engine abort event, per unit |
| chan_en | output | 2*NCH | Unit enabled |
| list_mode | output | 2*NCH | Unit in linked-list mode |
| start_pulse | output | 2*NCH | One-cycle doorbell start |
| irq_local | output | 2*NCH | Local interrupt level |
| msg_valid | output | 1 | Message write request this cycle |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench goes after three race cases. The first is a clear and a set event landing in the same cycle; a design that let the clear win would lose a completion. The second is two units raising remote events together; a design without a pending queue would drop one message or send them in the wrong order. The third is a repeated event on a flag that is already set; a design that keyed on the level would send a duplicate message. It also disables a unit that holds flags. A design that reset the flags along with the enable would lose interrupts, and one that kept tracking the engine while disabled would report a stale status code. Masking of the setup bits and the read-only and unimplemented offsets are covered so that stray storage shows up.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 8,
  parameter int AW  = 9 + ((NCH > 1) ? $clog2(NCH) : 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [2*NCH-1:0]  eng_run,
  input  logic [2*NCH-1:0]  eng_done,
  input  logic [2*NCH-1:0]  eng_abort,
  output logic [2*NCH-1:0]  chan_en,
  output logic [2*NCH-1:0]  list_mode,
  output logic [2*NCH-1:0]  start_pulse,
  output logic [2*NCH-1:0]  irq_local,
  output logic              msg_valid,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int NU = 2 * NCH;
  localparam int UW = AW - 8;

  logic [NU-1:0] en, lmode, sflag, aflag, pend_s, pend_a, start_q, hit, gnt_s, gnt_a;
  logic [6:0]  setup [NU];
  logic [1:0]  st [NU];
  logic [31:0] llp_l [NU], llp_h [NU], xsize [NU], sar_l [NU], sar_h [NU];
  logic [31:0] dar_l [NU], dar_h [NU], sad_l [NU], sad_h [NU], aad_l [NU], aad_h [NU], mdat [NU];
  logic [63:0] sel_addr;
  logic [31:0] sel_data;

  wire [UW-1:0] a_u  = reg_addr[AW-1:8];
  wire [7:0]    a_off = reg_addr[7:0];
  wire          a_ok = int'(reg_addr[AW-1:9]) < NCH;

  always_comb
    for (int u = 0; u < NU; u++) hit[u] = reg_wr && a_ok && (a_u == UW'(u));

  always_comb begin
    gnt_s = '0; gnt_a = '0; sel_addr = '0; sel_data = '0;
    for (int u = NU - 1; u >= 0; u--) begin
      if (pend_s[u] || pend_a[u]) begin
        gnt_s = '0; gnt_a = '0;
        gnt_s[u] = pend_s[u];
        gnt_a[u] = !pend_s[u];
        sel_addr = pend_s[u] ? {sad_h[u], sad_l[u]} : {aad_h[u], aad_l[u]};
        sel_data = mdat[u];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; lmode <= '0; sflag <= '0; aflag <= '0; pend_s <= '0; pend_a <= '0; start_q <= '0;
      msg_valid <= 1'b0; msg_addr <= '0; msg_data <= '0;
      for (int u = 0; u < NU; u++) begin
        setup[u] <= '0; st[u] <= '0;
        llp_l[u] <= '0; llp_h[u] <= '0; xsize[u] <= '0; sar_l[u] <= '0; sar_h[u] <= '0;
        dar_l[u] <= '0; dar_h[u] <= '0; sad_l[u] <= '0; sad_h[u] <= '0;
        aad_l[u] <= '0; aad_h[u] <= '0; mdat[u] <= '0;
      end
    end else begin
      msg_valid <= |(gnt_s | gnt_a);
      msg_addr  <= sel_addr;
      msg_data  <= sel_data;
      for (int u = 0; u < NU; u++) begin
        start_q[u] <= hit[u] && a_off == 8'h04 && reg_wdata[0] && en[u];
        if (hit[u]) begin
          case (a_off)
            8'h00: en[u]    <= reg_wdata[0];
            8'h10: llp_l[u] <= reg_wdata;
            8'h14: llp_h[u] <= reg_wdata;
            8'h1C: xsize[u] <= reg_wdata;
            8'h20: sar_l[u] <= reg_wdata;
            8'h24: sar_h[u] <= reg_wdata;
            8'h28: dar_l[u] <= reg_wdata;
            8'h2C: dar_h[u] <= reg_wdata;
            8'h34: lmode[u] <= reg_wdata[0];
            8'h88: setup[u] <= reg_wdata[6:0] & 7'h7D;
            8'h90: sad_l[u] <= reg_wdata;
            8'h94: sad_h[u] <= reg_wdata;
            8'hA0: aad_l[u] <= reg_wdata;
            8'hA4: aad_h[u] <= reg_wdata;
            8'hA8: mdat[u]  <= reg_wdata;
            default: ;
          endcase
        end
        if (!en[u] || (hit[u] && a_off == 8'h00 && !reg_wdata[0])) st[u] <= 2'd0;
        else if (eng_abort[u]) st[u] <= 2'd2;
        else if (eng_done[u])  st[u] <= 2'd3;
        else if (eng_run[u])   st[u] <= 2'd1;
        sflag[u]  <= eng_done[u]  | (sflag[u] & ~(hit[u] && a_off == 8'h8C && reg_wdata[0]));
        aflag[u]  <= eng_abort[u] | (aflag[u] & ~(hit[u] && a_off == 8'h8C && reg_wdata[2]));
        pend_s[u] <= (pend_s[u] & ~gnt_s[u]) | (eng_done[u]  & ~sflag[u] & setup[u][3]);
        pend_a[u] <= (pend_a[u] & ~gnt_a[u]) | (eng_abort[u] & ~aflag[u] & setup[u][5]);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (a_ok) begin
      case (a_off)
        8'h00: reg_rdata = {31'b0, en[a_u]};
        8'h10: reg_rdata = llp_l[a_u];
        8'h14: reg_rdata = llp_h[a_u];
        8'h1C: reg_rdata = xsize[a_u];
        8'h20: reg_rdata = sar_l[a_u];
        8'h24: reg_rdata = sar_h[a_u];
        8'h28: reg_rdata = dar_l[a_u];
        8'h2C: reg_rdata = dar_h[a_u];
        8'h34: reg_rdata = {31'b0, lmode[a_u]};
        8'h80: reg_rdata = {30'b0, st[a_u]};
        8'h84: reg_rdata = {29'b0, aflag[a_u], 1'b0, sflag[a_u]};
        8'h88: reg_rdata = {25'b0, setup[a_u]};
        8'h90: reg_rdata = sad_l[a_u];
        8'h94: reg_rdata = sad_h[a_u];
        8'hA0: reg_rdata = aad_l[a_u];
        8'hA4: reg_rdata = aad_h[a_u];
        8'hA8: reg_rdata = mdat[a_u];
        default: reg_rdata = '0;
      endcase
    end
  end

  always_comb
    for (int u = 0; u < NU; u++)
      irq_local[u] = (sflag[u] & setup[u][4]) | (aflag[u] & setup[u][6]);

  assign chan_en     = en;
  assign list_mode   = lmode;
  assign start_pulse = start_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH = 8,
  parameter int AW  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [AW-1:0]     reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [2*NCH-1:0]  en,
  input logic [2*NCH-1:0]  sflag,
  input logic [2*NCH-1:0]  aflag,
  input logic [2*NCH-1:0]  pend,
  input logic [2*NCH-1:0]  start_pulse,
  input logic [2*NCH-1:0]  irq_local,
  input logic              msg_valid
);
  // R9
  msg_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(|pend));

  for (genvar u = 0; u < 2 * NCH; u++) begin : g_u
    localparam logic [AW-1:0] CLR_ADDR = AW'((u / 2) * 512 + (u % 2) * 256 + 'h8C);
    // R4
    start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[u] |-> $past(reg_wr) && $past(en[u]));
    // R6
    stop_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sflag[u]) |-> $past(reg_wr && reg_addr == CLR_ADDR && reg_wdata[0]));
    // R6
    abort_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(aflag[u]) |-> $past(reg_wr && reg_addr == CLR_ADDR && reg_wdata[2]));
    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_local[u] |-> (sflag[u] || aflag[u]));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .en(en), .sflag(sflag), .aflag(aflag), .pend(pend_s | pend_a),
  .start_pulse(start_pulse), .irq_local(irq_local), .msg_valid(msg_valid)
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
  localparam int NCH = 8;
  localparam int NU  = 2 * NCH;
  localparam int AW  = 12;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NU-1:0] eng_run = '0, eng_done = '0, eng_abort = '0;
  logic [NU-1:0] chan_en, list_mode, start_pulse, irq_local;
  logic msg_valid;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int nvec = 0, nbad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_chan_regs #(.NCH(NCH)) dut (.*);

  localparam int NV = 22;
  localparam logic [75:0] VEC [NV] = '{
    {12'h010, 32'hDEADBEEF, 32'hDEADBEEF}, {12'h114, 32'h12345678, 32'h12345678},
    {12'h61C, 32'h00000400, 32'h00000400}, {12'hF20, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {12'hF24, 32'h5A5A5A5A, 32'h5A5A5A5A}, {12'h428, 32'h0BADF00D, 32'h0BADF00D},
    {12'h42C, 32'hCAFEF00D, 32'hCAFEF00D}, {12'h388, 32'hFFFFFFFF, 32'h0000007D},
    {12'h390, 32'h11112222, 32'h11112222}, {12'h394, 32'h33334444, 32'h33334444},
    {12'h3A0, 32'h55556666, 32'h55556666}, {12'h3A4, 32'h77778888, 32'h77778888},
    {12'h3A8, 32'h9999AAAA, 32'h9999AAAA}, {12'hA34, 32'hFFFFFFFF, 32'h00000001},
    {12'hB00, 32'hFFFFFFFE, 32'h00000000}, {12'h008, 32'hFFFFFFFF, 32'h00000000},
    {12'h0FC, 32'hFFFFFFFF, 32'h00000000}, {12'h104, 32'h00000001, 32'h00000000},
    {12'h08C, 32'h00000000, 32'h00000000}, {12'h080, 32'h00000003, 32'h00000000},
    {12'hE18, 32'hFFFFFFFF, 32'h00000000}, {12'hAAC, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({chan_en, list_mode, start_pulse, irq_local}, 0, "R1 outputs");
    chk(msg_valid, 0, "R1 msg_valid");
    rd(12'h088, v); chk(v, 0, "R1 setup");
    rd(12'h080, v); chk(v, 0, "R1 status");

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], v);
      chk(v, VEC[i][31:0], $sformatf("R2/R3 vector %0d", i));
    end
    chk(start_pulse, 0, "R4 doorbell on disabled unit");
    rd(12'h110, v); chk(v, 0, "R2 window independence rd");
    rd(12'h010, v); chk(v, 32'hDEADBEEF, "R2 window keep");

    // R10 enable and list mode
    wr(12'h000, 1); chk(chan_en[0], 1, "R10 chan_en");
    wr(12'h034, 1); chk(list_mode[0], 1, "R10 list_mode");
    // R4 doorbell pulse
    wr(12'h004, 1); chk(start_pulse, 16'h0001, "R4 pulse");
    @(negedge clk); chk(start_pulse, 0, "R4 one cycle");

    // R5 status
    eng_run[0] = 1; @(negedge clk);
    rd(12'h080, v); chk(v, 1, "R5 running");
    eng_run[0] = 0; eng_done[0] = 1; @(negedge clk); eng_done[0] = 0;
    rd(12'h080, v); chk(v, 3, "R5 complete");
    eng_done[0] = 1; eng_abort[0] = 1; @(negedge clk); eng_done[0] = 0; eng_abort[0] = 0;
    rd(12'h080, v); chk(v, 2, "R5 abort priority");
    wr(12'h000, 0);
    rd(12'h080, v); chk(v, 0, "R5 halted on disable");
    chk(chan_en[0], 0, "R10 chan_en cleared");
    eng_run[0] = 1; @(negedge clk); eng_run[0] = 0;
    rd(12'h080, v); chk(v, 0, "R5 ignores engine while disabled");
    // R6 flags kept across disable
    rd(12'h084, v); chk(v, 5, "R6 flags held");

    // R8 local interrupt
    chk(irq_local[0], 0, "R8 no enables");
    wr(12'h088, 32'h10); chk(irq_local[0], 1, "R8 local stop");
    // R7 clear
    wr(12'h08C, 0); rd(12'h084, v); chk(v, 5, "R7 zero clear no effect");
    wr(12'h08C, 1); rd(12'h084, v); chk(v, 4, "R7 clear stop");
    chk(irq_local[0], 0, "R8 stop cleared");
    wr(12'h088, 32'h40); chk(irq_local[0], 1, "R8 local abort");
    wr(12'h08C, 4); rd(12'h084, v); chk(v, 0, "R7 clear abort");
    chk(irq_local[0], 0, "R8 abort cleared");
    eng_done[0] = 1; reg_wr = 1; reg_addr = 12'h08C; reg_wdata = 1;
    @(negedge clk); eng_done[0] = 0; reg_wr = 0;
    rd(12'h084, v); chk(v, 1, "R7 set beats clear");

    // R9 messages
    wr(12'h288, 32'h08); wr(12'h290, 32'h00001000); wr(12'h294, 32'h2); wr(12'h2A8, 32'hBEEF);
    wr(12'h388, 32'h20); wr(12'h3A0, 32'h00003000); wr(12'h3A4, 32'h4); wr(12'h3A8, 32'hCAFE);
    eng_abort[3] = 1; eng_done[2] = 1; @(negedge clk); eng_abort[3] = 0; eng_done[2] = 0;
    chk(msg_valid, 0, "R9 not yet");
    @(negedge clk);
    chk(msg_valid, 1, "R9 first valid");
    chk(msg_addr, 64'h2_00001000, "R9 first addr (stop, unit 2)");
    chk(msg_data, 32'hBEEF, "R9 first data");
    @(negedge clk);
    chk(msg_valid, 1, "R9 second valid");
    chk(msg_addr, 64'h4_00003000, "R9 second addr (abort, unit 3)");
    chk(msg_data, 32'hCAFE, "R9 second data");
    @(negedge clk); chk(msg_valid, 0, "R9 queue empty");
    eng_done[2] = 1; @(negedge clk); eng_done[2] = 0;
    @(negedge clk); chk(msg_valid, 0, "R9 no repeat on set flag");
    @(negedge clk); chk(msg_valid, 0, "R9 no repeat later");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule